// File: doc/BRIEF.md
# Multi-Port GPIO Bank with Warm-Reset Retention

This block holds the configuration of a bank of general-purpose I/O ports. Each port has three registers, all one bit per pin: an output-level register, a direction register and a function-select register. The function-select register hands a pin to a dedicated peripheral in place of GPIO. Software reaches these registers over a simple single-cycle register bus. The block computes the level and output enable that the pad ring sees for every pin. Pins handed to a peripheral have their GPIO output enable held low. The peripheral path itself lives elsewhere.

The block has two reset inputs. The cold reset comes from power-up. The warm reset is raised while supply stays on. A cold reset clears every port. A warm reset clears only the ports that are not marked in the `RETAIN_MASK` parameter. The marked ports keep the configuration and output levels that were last written to them, so that external devices wired to those pins are not disturbed. Both resets take effect on assertion without waiting for a clock edge. Each reset is released through its own two-flop synchronizer.

Top module: `gpio_retain_bank`

## Requirements
- R1: While and after a cold reset, every register reads 0 and every `pin_oe` and `pin_out` bit is 0. Pins therefore default to inputs driving low, with GPIO selected.
- R2: `bus_addr` is {port index, register kind}. The register kind is the low two bits: 0 selects the output-level register, 1 the direction register, 2 the function-select register and 3 a reserved slot. A write with `bus_we` high takes effect at the rising edge and is visible on `bus_rdata` after that edge. `bus_rdata` returns the addressed register at all times.
- R3: The reserved register kind and port indexes of `NPORTS` or more read as 0, and writes to them change nothing.
- R4: For every pin, `pin_oe` is high exactly when its direction bit is 1 and its function-select bit is 0. `pin_out` equals the output-level bit while `pin_oe` is high and is 0 otherwise.
- R5: When `warm_rst_n` goes low, every port not marked in `RETAIN_MASK` clears at once, without waiting for a clock edge. Those ports stay cleared for as long as `warm_rst_n` is low.
- R6: The ports marked in `RETAIN_MASK` keep their registers and pin outputs unchanged through a warm reset. The default marks are on ports 1 and 7.
- R7: A cold reset clears the retained ports as well.
- R8: Bus writes are ignored while either reset is asserted. This applies to retained ports too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-up reset, active low, asserts without a clock |
| warm_rst_n | input | 1 | Warm reset, active low, asserts without a clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | clog2(NPORTS)+2 | {port index, register kind} |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the addressed register |
| pin_out | output | NPORTS*WIDTH | Pin output levels, port p at bits p*WIDTH upward |
| pin_oe | output | NPORTS*WIDTH | Pin output enables, same layout |

## Verification
The checker watches four things on every clock cycle:
- A pin never drives a level while its output enable is low.
- Ports that are not retained have no enabled outputs while warm reset is low.
- Retained pins hold steady through a warm reset.
- The whole bank is quiet under cold reset.

The bench scenarios show the rest:
- Clearing happens at the moment of warm reset, before any clock edge.
- Writes attempted during a reset are really dropped. This is seen by reading the registers back afterwards.
- Each register kind decodes to the right port, and the reserved slot reads as zero.
- Retained ports are cleared by a cold reset.

// File: rtl/gpio_retain_pkg.sv
// Package: shared register-kind encoding for the GPIO retention bank.
// Assumes the register kind occupies the two low address bits.
package gpio_retain_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_LEVEL = 2'd0,
        KIND_DIR   = 2'd1,
        KIND_FSEL  = 2'd2,
        KIND_RSVD  = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/gpio_rst_sync.sv
// Reset synchronizer: asserts its output as soon as arst_n falls, and releases it
// after two rising clock edges. Assumes arst_n may change at any time.
module gpio_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic stage1_q;
    logic stage2_q;

    // Two-stage shift of a constant 1, cleared asynchronously.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= 1'b1;
            stage2_q <= stage1_q;
        end
    end

    assign srst_n = stage2_q;

endmodule

// File: rtl/gpio_bus_dec.sv
// Register bus decoder: splits the address into port index and register kind.
// It produces per-port write strobes, gated by wr_ok, and muxes the read data.
// Assumes a port index of NPORTS or more is unmapped and reads as zero.
module gpio_bus_dec
    import gpio_retain_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int WIDTH  = 8
) (
    input  logic                           bus_we,
    input  logic                           wr_ok,
    input  logic [$clog2(NPORTS)+KIND_W-1:0] bus_addr,
    input  logic [NPORTS-1:0][WIDTH-1:0]   level_q,
    input  logic [NPORTS-1:0][WIDTH-1:0]   dir_q,
    input  logic [NPORTS-1:0][WIDTH-1:0]   fsel_q,
    output logic [NPORTS-1:0]              we_level,
    output logic [NPORTS-1:0]              we_dir,
    output logic [NPORTS-1:0]              we_fsel,
    output logic [WIDTH-1:0]               bus_rdata
);

    localparam int IDX_W = $clog2(NPORTS);

    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             idx_valid;

    assign kind      = reg_kind_e'(bus_addr[KIND_W-1:0]);
    assign idx       = bus_addr[IDX_W+KIND_W-1:KIND_W];
    assign idx_valid = (32'(idx) < NPORTS);

    // Write strobe per port and register kind.
    always_comb begin
        we_level = '0;
        we_dir   = '0;
        we_fsel  = '0;
        if (bus_we && wr_ok && idx_valid) begin
            case (kind)
                KIND_LEVEL: we_level[idx] = 1'b1;
                KIND_DIR:   we_dir[idx]   = 1'b1;
                KIND_FSEL:  we_fsel[idx]  = 1'b1;
                default:    ;
            endcase
        end
    end

    // Read-back mux of the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (idx_valid) begin
            case (kind)
                KIND_LEVEL: bus_rdata = level_q[idx];
                KIND_DIR:   bus_rdata = dir_q[idx];
                KIND_FSEL:  bus_rdata = fsel_q[idx];
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
// One GPIO port: the level, direction and function-select registers plus the pin model.
// RETAIN selects which reset clears the port: only the cold reset, or either reset.
// Assumes both reset inputs are already synchronized on release.
module gpio_port_regs #(
    parameter int WIDTH  = 8,
    parameter bit RETAIN = 1'b0
) (
    input  logic             clk,
    input  logic             cold_sn,
    input  logic             any_sn,
    input  logic             we_level,
    input  logic             we_dir,
    input  logic             we_fsel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] fsel_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    logic port_rst_n;

    // Pick the reset policy for this port.
    generate
        if (RETAIN) begin : g_keep
            assign port_rst_n = cold_sn;
        end else begin : g_clear
            assign port_rst_n = any_sn;
        end
    endgenerate

    // Register storage, cleared by the selected reset.
    always_ff @(posedge clk or negedge port_rst_n) begin
        if (!port_rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
            fsel_q  <= '0;
        end else begin
            if (we_level) level_q <= wdata;
            if (we_dir)   dir_q   <= wdata;
            if (we_fsel)  fsel_q  <= wdata;
        end
    end

    // Pin model: drive only output pins that are still in GPIO use.
    always_comb begin
        pin_oe  = dir_q & ~fsel_q;
        pin_out = level_q & pin_oe;
    end

endmodule

// File: rtl/gpio_retain_bank.sv
// Top level of the GPIO bank. It synchronizes both resets on release, decodes the
// register bus, and holds NPORTS port register sets. Ports set in RETAIN_MASK
// survive a warm reset. Assumes the resets are glitch-free when asserted.
module gpio_retain_bank
    import gpio_retain_pkg::*;
#(
    parameter int               NPORTS      = 8,
    parameter int               WIDTH       = 8,
    parameter logic [NPORTS-1:0] RETAIN_MASK = 8'b1000_0010
) (
    input  logic                             clk,
    input  logic                             cold_rst_n,
    input  logic                             warm_rst_n,
    input  logic                             bus_we,
    input  logic [$clog2(NPORTS)+KIND_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]                 bus_wdata,
    output logic [WIDTH-1:0]                 bus_rdata,
    output logic [NPORTS*WIDTH-1:0]          pin_out,
    output logic [NPORTS*WIDTH-1:0]          pin_oe
);

    logic cold_sn;
    logic any_sn;
    logic any_raw_n;

    logic [NPORTS-1:0][WIDTH-1:0] level_q;
    logic [NPORTS-1:0][WIDTH-1:0] dir_q;
    logic [NPORTS-1:0][WIDTH-1:0] fsel_q;
    logic [NPORTS-1:0]            we_level;
    logic [NPORTS-1:0]            we_dir;
    logic [NPORTS-1:0]            we_fsel;

    // Combined raw reset: low while either source is low.
    assign any_raw_n = cold_rst_n & warm_rst_n;

    gpio_rst_sync i_cold_sync (
        .clk    (clk),
        .arst_n (cold_rst_n),
        .srst_n (cold_sn)
    );

    gpio_rst_sync i_any_sync (
        .clk    (clk),
        .arst_n (any_raw_n),
        .srst_n (any_sn)
    );

    gpio_bus_dec #(
        .NPORTS (NPORTS),
        .WIDTH  (WIDTH)
    ) i_dec (
        .bus_we    (bus_we),
        .wr_ok     (any_sn),
        .bus_addr  (bus_addr),
        .level_q   (level_q),
        .dir_q     (dir_q),
        .fsel_q    (fsel_q),
        .we_level  (we_level),
        .we_dir    (we_dir),
        .we_fsel   (we_fsel),
        .bus_rdata (bus_rdata)
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            gpio_port_regs #(
                .WIDTH  (WIDTH),
                .RETAIN (RETAIN_MASK[p])
            ) i_port (
                .clk      (clk),
                .cold_sn  (cold_sn),
                .any_sn   (any_sn),
                .we_level (we_level[p]),
                .we_dir   (we_dir[p]),
                .we_fsel  (we_fsel[p]),
                .wdata    (bus_wdata),
                .level_q  (level_q[p]),
                .dir_q    (dir_q[p]),
                .fsel_q   (fsel_q[p]),
                .pin_out  (pin_out[p*WIDTH +: WIDTH]),
                .pin_oe   (pin_oe[p*WIDTH +: WIDTH])
            );
        end
    endgenerate

endmodule

// File: rtl/gpio_retain_bank_chk.sv
// Checker for gpio_retain_bank. It watches the pin outputs against the two reset
// inputs. It is attached to every instance of the top by the bind at the end of this file.
module gpio_retain_bank_chk #(
    parameter int                NPORTS      = 8,
    parameter int                WIDTH       = 8,
    parameter logic [NPORTS-1:0] RETAIN_MASK = 8'b1000_0010
) (
    input logic                    clk,
    input logic                    cold_rst_n,
    input logic                    warm_rst_n,
    input logic [NPORTS*WIDTH-1:0] pin_out,
    input logic [NPORTS*WIDTH-1:0] pin_oe
);

    logic [NPORTS*WIDTH-1:0] keep_bits;

    // Expand the per-port retention mask to per-pin bits.
    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_bits
            assign keep_bits[p*WIDTH +: WIDTH] = {WIDTH{RETAIN_MASK[p]}};
        end
    endgenerate

    AST_NO_DRIVE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (pin_out & ~pin_oe) == '0); // R4

    AST_CLEARED_IN_WARM: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |-> ((pin_oe | pin_out) & ~keep_bits) == '0); // R5

    AST_KEPT_IN_WARM: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!warm_rst_n && $past(!warm_rst_n)) |->
            ($stable(pin_oe & keep_bits) && $stable(pin_out & keep_bits))); // R6

    AST_QUIET_IN_COLD: assert property (@(posedge clk)
        !cold_rst_n |-> (pin_oe == '0 && pin_out == '0)); // R7

endmodule

bind gpio_retain_bank gpio_retain_bank_chk #(
    .NPORTS      (NPORTS),
    .WIDTH       (WIDTH),
    .RETAIN_MASK (RETAIN_MASK)
) i_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/test_gpio_retain_bank.sv
module test_gpio_retain_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int W  = 8;
    localparam int AW = 5;
    localparam logic [NP-1:0] KEEP = 8'b1000_0010;

    logic            clk = 1'b0;
    logic            cold_rst_n;
    logic            warm_rst_n;
    logic            bus_we;
    logic [AW-1:0]   bus_addr;
    logic [W-1:0]    bus_wdata;
    logic [W-1:0]    bus_rdata;
    logic [NP*W-1:0] pin_out;
    logic [NP*W-1:0] pin_oe;

    logic [W-1:0] m_lvl  [NP];
    logic [W-1:0] m_dir  [NP];
    logic [W-1:0] m_fsel [NP];

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_retain_bank i_gpio_retain_bank (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .warm_rst_n (warm_rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
        int p = int'(a[AW-1:2]);
        case (a[1:0])
            2'd0:    return m_lvl[p];
            2'd1:    return m_dir[p];
            2'd2:    return m_fsel[p];
            default: return '0;
        endcase
    endfunction

    function automatic logic [NP*W-1:0] exp_oe();
        logic [NP*W-1:0] v;
        for (int p = 0; p < NP; p++) v[p*W +: W] = m_dir[p] & ~m_fsel[p];
        return v;
    endfunction

    function automatic logic [NP*W-1:0] exp_out();
        logic [NP*W-1:0] v;
        for (int p = 0; p < NP; p++) v[p*W +: W] = m_lvl[p] & m_dir[p] & ~m_fsel[p];
        return v;
    endfunction

    task automatic check(input string req, input logic [NP*W-1:0] act, input logic [NP*W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear(input bit all_ports);
        for (int p = 0; p < NP; p++) begin
            if (all_ports || !KEEP[p]) begin
                m_lvl[p] = '0; m_dir[p] = '0; m_fsel[p] = '0;
            end
        end
    endtask

    // Write at one rising edge; the model follows only when the write is legal.
    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d, input bit legal);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        if (legal) begin
            case (a[1:0])
                2'd0: m_lvl[a[AW-1:2]]  = d;
                2'd1: m_dir[a[AW-1:2]]  = d;
                2'd2: m_fsel[a[AW-1:2]] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_regs(input string req);
        for (int a = 0; a < (1 << AW); a++) begin
            bus_addr = AW'(a);
            #1;
            check(req, {{(NP-1)*W{1'b0}}, bus_rdata}, {{(NP-1)*W{1'b0}}, exp_read(AW'(a))});
        end
    endtask

    task automatic check_pins(input string req);
        check({req, " oe"},  pin_oe,  exp_oe());
        check({req, " out"}, pin_out, exp_out());
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a = AW'($urandom);
            bus_write(a, W'($urandom), 1'b1);
            bus_addr = a;
            #1;
            check("R2 readback", {{(NP-1)*W{1'b0}}, bus_rdata}, {{(NP-1)*W{1'b0}}, exp_read(a)});
            check_pins("R4 pins");
        end
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        cold_rst_n = 1'b1; warm_rst_n = 1'b1;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        model_clear(1'b1);
        #1 cold_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_pins("R1 cold state");
        check_regs("R1 cold regs");
        // R8: writes during cold reset are dropped
        bus_write(5'd4, 8'hFF, 1'b0);
        bus_write(5'd5, 8'hFF, 1'b0);
        @(negedge clk) cold_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_regs("R8 no write in cold reset");

        // Directed R2/R3/R4 cases
        bus_write(5'd0, 8'hA5, 1'b1);
        bus_write(5'd1, 8'hF0, 1'b1);
        bus_write(5'd2, 8'h30, 1'b1);
        check_pins("R4 mixed dir/fsel");
        bus_write(5'd3, 8'hEE, 1'b1);
        bus_write(5'd31, 8'h77, 1'b1);
        check_regs("R3 reserved slot");

        fill_random(300);
        check_regs("R2 all regs");

        // Make sure retained ports drive something
        bus_write(5'd4, 8'h5A, 1'b1);
        bus_write(5'd5, 8'hFF, 1'b1);
        bus_write(5'd6, 8'h00, 1'b1);
        bus_write(5'd28, 8'hC3, 1'b1);
        bus_write(5'd29, 8'h0F, 1'b1);
        bus_write(5'd30, 8'h01, 1'b1);

        // Warm reset: non-retained clear immediately, retained keep state
        @(negedge clk) warm_rst_n = 1'b0;
        model_clear(1'b0);
        #1 check_pins("R5 immediate clear");
        bus_write(5'd4, 8'h11, 1'b0);
        bus_write(5'd8, 8'h22, 1'b0);
        bus_write(5'd29, 8'hFF, 1'b0);
        repeat (4) @(negedge clk);
        check_pins("R6 retained held");
        check_regs("R8 no write in warm reset");
        @(negedge clk) warm_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_regs("R6 after warm release");

        fill_random(200);

        // Cold reset clears retained ports too
        @(negedge clk) cold_rst_n = 1'b0;
        model_clear(1'b1);
        #1 check_pins("R7 cold clears all");
        repeat (2) @(negedge clk);
        check_regs("R7 cold regs");
        @(negedge clk) cold_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        fill_random(50);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule